// File: doc/BRIEF.md
# Radix-8 Booth Pipelined Multiplier

This block multiplies a 56-bit multiplier operand by a 64-bit multiplicand in a three-stage pipeline that can take a new operation on every clock. The first stage recodes the multiplier into nineteen radix-8 digits in the range -4..+4. In the same stage an adder forms three times the multiplicand, which is the only multiple that a shift cannot give. The second stage selects one partial product per digit and compresses all rows into a carry/sum pair with 3:2 counters. The third stage adds that pair with a carry-propagate adder and registers the 120-bit product.

A mode input selects between two interpretations. In fixed-point mode both operands are two's complement and the product is a signed 120-bit value. In fraction mode the operands are unsigned magnitudes and their signs arrive on separate pins. The result sign is the XOR of those pins. A flag reports that a product of two hex-normalized fractions has a zero leading hex digit and so needs a one-digit left shift. Exponents and normalization shifting happen outside the block.

Both data edges use valid/ready. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. A result is delivered on an edge where `out_valid` and `out_ready` are both high. The pipeline advances as a whole: `in_ready` is high when the output register is empty or is being drained in the same cycle. While the output stalls, every stage holds its contents.

Top module: `booth8_mult`

## Requirements
- R1: With `out_ready` held high, `in_ready` stays high, one operation is accepted per cycle, and each result shows on `out_valid` after the third rising edge, counting the edge that accepted it. Results leave in order, each exactly once.
- R2: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_valid`, `out_prod`, `out_sign` and `out_shift1` keep their values on the next cycle.
- R3: The multiplier is extended by one bit (sign in fixed mode, zero in fraction mode) and read in overlapping groups {a[3i+2], a[3i+1], a[3i], a[3i-1]} with a[-1] = 0. Each group becomes the digit -4*g3 + 2*g2 + g1 + g0. A digit of ±3 uses an adder-formed 3x multiple. Products are exact for multipliers made of every repeated 3-bit pattern.
- R4: When `in_mode` = 0 (fixed point), `out_prod` is the 120-bit two's-complement product of the signed operands, including the most negative values of both.
- R5: When `in_mode` = 1 (fraction), `out_prod` is the unsigned 120-bit product of the two operands taken as magnitudes.
- R6: In fraction mode `out_sign` = `in_sign_a` XOR `in_sign_b`. In fixed mode `out_sign` equals `out_prod[119]`, and the sign pins have no effect on any output.
- R7: `out_shift1` is 1 exactly when the mode is fraction, `in_a[55:52]` and `in_b[63:60]` are both non-zero, and `out_prod[119:116]` is zero. When it is 1, `out_prod[115:112]` is non-zero.
- R8: A synchronous active-high `rst` clears every stage's valid bit. After it, `out_valid` is 0, `in_ready` is 1, and operations that were in flight never appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid bits |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Pipeline can take an operation this cycle |
| in_mode | input | 1 | 0 = fixed-point two's complement, 1 = sign-magnitude fraction |
| in_a | input | 56 | Multiplier operand (recoded) |
| in_b | input | 64 | Multiplicand operand |
| in_sign_a | input | 1 | Sign of in_a in fraction mode |
| in_sign_b | input | 1 | Sign of in_b in fraction mode |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_prod | output | 120 | Product (signed or magnitude by mode) |
| out_sign | output | 1 | Result sign |
| out_shift1 | output | 1 | Normalized fraction product needs a one-hex-digit left shift |

## Verification
The product path is driven with extreme signed values (most negative times most negative, all ones), with zero and unit operands, and with multipliers built from each repeated 3-bit pattern. These last ones force every digit value, including ±3 and ±4, so a wrong multiple or a wrong complement shows up in specific rows. Sign pins are toggled in fixed mode and varied in fraction mode to separate sign logic from magnitude logic. The smallest and largest normalized fraction pairs, together with unnormalized and fixed-mode cases, tell apart the two outcomes of the shift flag and its gating. A long random stream with random output stalls, followed by a reset in mid-flight, checks ordering, holding under back-pressure and the flush of in-flight work.

// File: rtl/booth8_pkg.sv
package booth8_pkg;

  typedef enum logic {
    MODE_FIXED = 1'b0,
    MODE_FRAC  = 1'b1
  } mul_mode_e;

  // One recoded digit: magnitude select (one-hot: bit0=1x, bit1=2x,
  // bit2=3x, bit3=4x, none = zero) and a negate flag.
  typedef struct packed {
    logic       neg;
    logic [3:0] sel;
  } bdigit_t;

  function automatic bdigit_t recode_group(input logic [3:0] g);
    bdigit_t d;
    d.neg = 1'b0;
    d.sel = 4'b0000;
    unique case (g)
      4'b0000, 4'b1111: d.sel = 4'b0000;
      4'b0001, 4'b0010: d.sel = 4'b0001;
      4'b0011, 4'b0100: d.sel = 4'b0010;
      4'b0101, 4'b0110: d.sel = 4'b0100;
      4'b0111:          d.sel = 4'b1000;
      4'b1000:          begin d.sel = 4'b1000; d.neg = 1'b1; end
      4'b1001, 4'b1010: begin d.sel = 4'b0100; d.neg = 1'b1; end
      4'b1011, 4'b1100: begin d.sel = 4'b0010; d.neg = 1'b1; end
      4'b1101, 4'b1110: begin d.sel = 4'b0001; d.neg = 1'b1; end
      default:          d.sel = 4'b0000;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/booth8_recode.sv
module booth8_recode
  import booth8_pkg::*;
#(
  parameter int MW = 56,
  parameter int XW = 64,
  localparam int ND  = (MW + 3) / 3,
  localparam int AW  = 3 * ND,
  localparam int MXW = XW + 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic                  v_in,
  input  logic                  mode,
  input  logic [MW-1:0]         a,
  input  logic [XW-1:0]         b,
  input  logic                  sa,
  input  logic                  sb,
  output logic                  v_q,
  output logic                  mode_q,
  output logic                  sign_q,
  output logic                  norm_q,
  output bdigit_t [ND-1:0]      dig_q,
  output logic [MXW-1:0]        x_q,
  output logic [MXW-1:0]        x3_q
);

  logic            fill_a;
  logic            fill_b;
  logic [AW:0]     a_ext;
  logic [MXW-1:0]  x_ext;
  logic [MXW-1:0]  x3_d;
  bdigit_t [ND-1:0] dig_d;

  assign fill_a = (mode == MODE_FIXED) ? a[MW-1] : 1'b0;
  assign fill_b = (mode == MODE_FIXED) ? b[XW-1] : 1'b0;
  assign a_ext  = {{(AW-MW){fill_a}}, a, 1'b0};
  assign x_ext  = {{(MXW-XW){fill_b}}, b};

  // The one hard multiple: 3x = x + 2x through a real adder.
  assign x3_d = x_ext + {x_ext[MXW-2:0], 1'b0};

  for (genvar i = 0; i < ND; i++) begin : g_dig
    assign dig_d[i] = recode_group(a_ext[3*i+3 -: 4]);

    assert_digit_onehot_R3: assert property (@(posedge clk) disable iff (rst)
      v_q |-> ($onehot0(dig_q[i].sel) && (!dig_q[i].neg || (|dig_q[i].sel))));
  end

  always_ff @(posedge clk) begin
    if (rst)     v_q <= 1'b0;
    else if (en) v_q <= v_in;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      mode_q <= mode;
      sign_q <= sa ^ sb;
      norm_q <= (mode == MODE_FRAC) && (|a[MW-1:MW-4]) && (|b[XW-1:XW-4]);
      dig_q  <= dig_d;
      x_q    <= x_ext;
      x3_q   <= x3_d;
    end
  end

  assert_triple_mult_R3: assert property (@(posedge clk) disable iff (rst)
    v_q |-> (x3_q == (x_q * MXW'(3))));

endmodule

// File: rtl/booth8_reduce.sv
module booth8_reduce
  import booth8_pkg::*;
#(
  parameter int MW = 56,
  parameter int XW = 64,
  localparam int ND  = (MW + 3) / 3,
  localparam int NR  = ND + 1,
  localparam int MXW = XW + 4,
  localparam int PW  = MW + XW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             v_in,
  input  logic             mode_in,
  input  logic             sign_in,
  input  logic             norm_in,
  input  bdigit_t [ND-1:0] dig,
  input  logic [MXW-1:0]   x,
  input  logic [MXW-1:0]   x3,
  output logic             v_q,
  output logic             mode_q,
  output logic             sign_q,
  output logic             norm_q,
  output logic [PW-1:0]    sum_q,
  output logic [PW-1:0]    carry_q
);

  logic [MXW-1:0] x2;
  logic [MXW-1:0] x4;
  logic [PW-1:0]  rows  [NR];
  logic [PW-1:0]  inj;
  logic [PW-1:0]  acc_s [NR-1];
  logic [PW-1:0]  acc_c [NR-1];

  assign x2 = {x[MXW-2:0], 1'b0};
  assign x4 = {x[MXW-3:0], 2'b00};

  // Partial-product rows: 4-to-1 magnitude pick, true/complement, sign-extend.
  for (genvar i = 0; i < ND; i++) begin : g_row
    logic [MXW-1:0] mag;
    logic [MXW-1:0] pp;
    assign mag = ({MXW{dig[i].sel[0]}} & x)  |
                 ({MXW{dig[i].sel[1]}} & x2) |
                 ({MXW{dig[i].sel[2]}} & x3) |
                 ({MXW{dig[i].sel[3]}} & x4);
    assign pp      = mag ^ {MXW{dig[i].neg}};
    assign rows[i] = {{(PW-MXW){pp[MXW-1]}}, pp} << (3 * i);
  end

  // Extra row: the +1 of each complemented row at its least significant place.
  always_comb begin
    inj = '0;
    for (int i = 0; i < ND; i++) inj[3*i] = dig[i].neg;
  end
  assign rows[ND] = inj;

  // Carry-save chain of 3:2 counters.
  assign acc_s[0] = rows[0];
  assign acc_c[0] = rows[1];
  for (genvar j = 1; j < NR - 1; j++) begin : g_csa
    logic [PW-1:0] p;
    logic [PW-1:0] q;
    logic [PW-1:0] r;
    assign p = acc_s[j-1];
    assign q = acc_c[j-1];
    assign r = rows[j+1];
    assign acc_s[j] = p ^ q ^ r;
    assign acc_c[j] = {((p[PW-2:0] & q[PW-2:0]) | (p[PW-2:0] & r[PW-2:0]) |
                        (q[PW-2:0] & r[PW-2:0])), 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst)     v_q <= 1'b0;
    else if (en) v_q <= v_in;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      mode_q  <= mode_in;
      sign_q  <= sign_in;
      norm_q  <= norm_in;
      sum_q   <= acc_s[NR-2];
      carry_q <= acc_c[NR-2];
    end
  end

endmodule

// File: rtl/booth8_cpa.sv
module booth8_cpa
  import booth8_pkg::*;
#(
  parameter int PW = 120
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          v_in,
  input  logic          mode_in,
  input  logic          sign_in,
  input  logic          norm_in,
  input  logic [PW-1:0] sum_in,
  input  logic [PW-1:0] carry_in,
  output logic          v_q,
  output logic [PW-1:0] prod_q,
  output logic          sign_q,
  output logic          shift1_q
);

  logic [PW-1:0] prod_d;

  assign prod_d = sum_in + carry_in;

  always_ff @(posedge clk) begin
    if (rst)     v_q <= 1'b0;
    else if (en) v_q <= v_in;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      prod_q   <= prod_d;
      sign_q   <= (mode_in == MODE_FRAC) ? sign_in : prod_d[PW-1];
      shift1_q <= norm_in && (prod_d[PW-1:PW-4] == 4'h0);
    end
  end

  // Normalized fractions: a zero leading digit means the next one is not zero.
  assert_shift_one_digit_R7: assert property (@(posedge clk) disable iff (rst)
    (v_q && shift1_q) |-> (prod_q[PW-5:PW-8] != 4'h0));

endmodule

// File: rtl/booth8_mult.sv
module booth8_mult
  import booth8_pkg::*;
#(
  parameter int MW = 56,
  parameter int XW = 64,
  localparam int ND  = (MW + 3) / 3,
  localparam int MXW = XW + 4,
  localparam int PW  = MW + XW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_mode,
  input  logic [MW-1:0] in_a,
  input  logic [XW-1:0] in_b,
  input  logic          in_sign_a,
  input  logic          in_sign_b,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] out_prod,
  output logic          out_sign,
  output logic          out_shift1
);

  logic             adv;
  logic             s1_v, s1_mode, s1_sign, s1_norm;
  bdigit_t [ND-1:0] s1_dig;
  logic [MXW-1:0]   s1_x, s1_x3;
  logic             s2_v, s2_mode, s2_sign, s2_norm;
  logic [PW-1:0]    s2_sum, s2_carry;

  // Whole-pipeline advance: move when the output slot is free or draining.
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  booth8_recode #(.MW(MW), .XW(XW)) u_recode (
    .clk(clk), .rst(rst), .en(adv), .v_in(in_valid),
    .mode(in_mode), .a(in_a), .b(in_b), .sa(in_sign_a), .sb(in_sign_b),
    .v_q(s1_v), .mode_q(s1_mode), .sign_q(s1_sign), .norm_q(s1_norm),
    .dig_q(s1_dig), .x_q(s1_x), .x3_q(s1_x3)
  );

  booth8_reduce #(.MW(MW), .XW(XW)) u_reduce (
    .clk(clk), .rst(rst), .en(adv), .v_in(s1_v),
    .mode_in(s1_mode), .sign_in(s1_sign), .norm_in(s1_norm),
    .dig(s1_dig), .x(s1_x), .x3(s1_x3),
    .v_q(s2_v), .mode_q(s2_mode), .sign_q(s2_sign), .norm_q(s2_norm),
    .sum_q(s2_sum), .carry_q(s2_carry)
  );

  booth8_cpa #(.PW(PW)) u_cpa (
    .clk(clk), .rst(rst), .en(adv), .v_in(s2_v),
    .mode_in(s2_mode), .sign_in(s2_sign), .norm_in(s2_norm),
    .sum_in(s2_sum), .carry_in(s2_carry),
    .v_q(out_valid), .prod_q(out_prod), .sign_q(out_sign), .shift1_q(out_shift1)
  );

  assert_hold_on_stall_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_prod) &&
                                   $stable(out_sign) && $stable(out_shift1)));

endmodule

// File: tb/booth8_mult_tb_top.sv
`timescale 1ns/1ps
module booth8_mult_tb_top;

  typedef struct {
    logic [119:0] prod;
    logic         sign;
    logic         sh;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic         in_mode = 1'b0;
  logic [55:0]  in_a = '0;
  logic [63:0]  in_b = '0;
  logic         in_sign_a = 1'b0;
  logic         in_sign_b = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [119:0] out_prod;
  logic         out_sign;
  logic         out_shift1;

  int   n_checks = 0;
  int   n_fail   = 0;
  int   n_sent   = 0;
  int   n_recv   = 0;
  bit   done     = 1'b0;
  bit   bp_rand  = 1'b0;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  booth8_mult dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_a(in_a), .in_b(in_b),
    .in_sign_a(in_sign_a), .in_sign_b(in_sign_b),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_prod(out_prod), .out_sign(out_sign), .out_shift1(out_shift1)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [119:0] act, input logic [119:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  function automatic exp_t model(input logic [55:0] a, input logic [63:0] b,
                                 input logic sa, input logic sb,
                                 input logic md, input string tag);
    exp_t e;
    logic [119:0] ea, eb;
    if (md == 1'b0) begin
      ea = {{64{a[55]}}, a};
      eb = {{56{b[63]}}, b};
      e.prod = ea * eb;
      e.sign = e.prod[119];
      e.sh   = 1'b0;
    end else begin
      ea = {64'd0, a};
      eb = {56'd0, b};
      e.prod = ea * eb;
      e.sign = sa ^ sb;
      e.sh   = (a[55:52] != 0) && (b[63:60] != 0) && (e.prod[119:116] == 0);
    end
    e.tag = tag;
    return e;
  endfunction

  // Output monitor: ordering, value, sign and flag checks, stall holding.
  logic         prev_stall = 1'b0;
  logic [119:0] prev_prod;
  logic         prev_sign, prev_sh;
  always @(negedge clk) begin
    if (rst) begin
      prev_stall = 1'b0;
    end else begin
      if (prev_stall) begin
        chk(out_valid, "R2", "valid held during stall", 120'(out_valid), 120'd1);
        chk(out_prod == prev_prod && out_sign == prev_sign && out_shift1 == prev_sh,
            "R2", "result held during stall", out_prod, prev_prod);
      end
      if (out_valid && !out_ready)
        chk(!in_ready, "R2", "in_ready low during stall", 120'(in_ready), 120'd0);
      prev_stall = out_valid && !out_ready;
      prev_prod  = out_prod;
      prev_sign  = out_sign;
      prev_sh    = out_shift1;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R1", "unexpected result", out_prod, 120'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          n_recv++;
          chk(out_prod == e.prod, e.tag, "product", out_prod, e.prod);
          chk(out_sign == e.sign, "R6", "sign", 120'(out_sign), 120'(e.sign));
          chk(out_shift1 == e.sh, "R7", "shift flag", 120'(out_shift1), 120'(e.sh));
        end
      end
    end
  end

  always @(posedge clk) begin
    #1;
    if (bp_rand) out_ready = ($urandom % 3) != 0;
  end

  // Called at a rising edge + 1 ns; returns at a rising edge + 1 ns.
  task automatic send(input logic [55:0] a, input logic [63:0] b,
                      input logic sa, input logic sb, input logic md,
                      input string tag);
    bit acc;
    in_valid = 1'b1; in_a = a; in_b = b;
    in_sign_a = sa; in_sign_b = sb; in_mode = md;
    acc = 1'b0;
    while (!acc) begin
      @(negedge clk);
      if (in_ready) begin
        exp_q.push_back(model(a, b, sa, sb, md, tag));
        n_sent++;
        acc = 1'b1;
      end
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
  endtask

  task automatic drain();
    int n;
    n = 0;
    while (exp_q.size() != 0 && n < 3000) begin
      @(posedge clk); #1; n++;
    end
    chk(exp_q.size() == 0, "R1", "all results delivered", 120'(exp_q.size()), 120'd0);
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  task automatic t_reset_state();
    @(negedge clk);
    chk(!out_valid, "R8", "out_valid after reset", 120'(out_valid), 120'd0);
    chk(in_ready, "R8", "in_ready after reset", 120'(in_ready), 120'd1);
    @(posedge clk); #1;
  endtask

  task automatic t_latency();
    int cyc;
    send(56'd5, 64'd7, 1'b0, 1'b0, 1'b0, "R1");
    cyc = 1;
    while (cyc < 10) begin
      @(negedge clk);
      if (out_valid) break;
      @(posedge clk); #1; cyc++;
    end
    chk(cyc == 3, "R1", "latency in edges", 120'(cyc), 120'd3);
    @(posedge clk); #1;
    drain();
  endtask

  task automatic t_fixed_corners();
    logic [55:0] amin, amax;
    logic [63:0] bmin, bmax;
    amin = 56'h80000000000000; amax = 56'h7FFFFFFFFFFFFF;
    bmin = 64'h8000000000000000; bmax = 64'h7FFFFFFFFFFFFFFF;
    send(amin, bmin, 1'b0, 1'b0, 1'b0, "R4");
    send(amin, bmax, 1'b0, 1'b0, 1'b0, "R4");
    send(amax, bmin, 1'b0, 1'b0, 1'b0, "R4");
    send('1, '1, 1'b0, 1'b0, 1'b0, "R4");
    send('1, bmin, 1'b0, 1'b0, 1'b0, "R4");
    send(56'd0, bmin, 1'b0, 1'b0, 1'b0, "R4");
    send(56'd1, 64'h123456789ABCDEF0, 1'b0, 1'b0, 1'b0, "R4");
    // R6: sign pins set in fixed mode must not matter
    send(56'hFFFFFFFFFFFFFD, 64'd9, 1'b1, 1'b0, 1'b0, "R6");
    send(56'd3, 64'd9, 1'b1, 1'b1, 1'b0, "R6");
    drain();
  endtask

  task automatic t_frac_corners();
    send('1, '1, 1'b0, 1'b1, 1'b1, "R5");
    send('1, '1, 1'b1, 1'b1, 1'b1, "R5");
    send(56'd0, '1, 1'b1, 1'b0, 1'b1, "R5");
    send(56'd1, 64'd1, 1'b0, 1'b0, 1'b1, "R5");
    send(56'h80000000000000, 64'h8000000000000000, 1'b1, 1'b0, 1'b1, "R5");
    drain();
  endtask

  task automatic t_digit_patterns();
    for (int t = 0; t < 8; t++) begin
      logic [55:0] a;
      for (int k = 0; k < 56; k++) a[k] = t[k % 3];
      send(a, 64'hFFFFFFFFFFFFFFFF, 1'b0, 1'b0, 1'b0, "R3");
      send(a, 64'hD5A3C97E12B4F061, 1'b0, 1'b1, 1'b1, "R3");
      send(a, 64'h5555555555555555, 1'b0, 1'b0, 1'b0, "R3");
    end
    drain();
  endtask

  task automatic t_shift_flag();
    send(56'h10000000000000, 64'h1000000000000000, 1'b0, 1'b0, 1'b1, "R7");
    send('1, '1, 1'b0, 1'b0, 1'b1, "R7");
    send(56'h08000000000000, 64'h1000000000000000, 1'b0, 1'b0, 1'b1, "R7");
    send(56'h10000000000000, 64'h1000000000000000, 1'b0, 1'b0, 1'b0, "R7");
    send(56'h2AAAAAAAAAAAAA, 64'h3333333333333333, 1'b0, 1'b1, 1'b1, "R7");
    drain();
  endtask

  task automatic t_stream(input int n, input bit stall);
    int cyc;
    bp_rand = stall;
    cyc = 0;
    for (int i = 0; i < n; i++) begin
      logic [63:0] r;
      r = rnd64();
      send(r[55:0], rnd64(), r[60], r[61], r[62], r[62] ? "R5" : "R4");
      cyc++;
    end
    bp_rand = 1'b0;
    out_ready = 1'b1;
    drain();
  endtask

  task automatic t_back_to_back();
    time t0;
    t0 = $time;
    for (int i = 0; i < 16; i++)
      send(56'(i * 977), 64'(i * 31337) ^ 64'hF00F, 1'b0, 1'b0, i[0], "R1");
    chk(($time - t0) == 16 * 5, "R1", "one accept per cycle",
        120'($time - t0), 120'(16 * 5));
    drain();
  endtask

  task automatic t_reset_flush();
    send(56'd11, 64'd13, 1'b0, 1'b0, 1'b0, "R8");
    send(56'd17, 64'd19, 1'b0, 1'b0, 1'b0, "R8");
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    exp_q.delete();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!out_valid, "R8", "no stale result after reset", 120'(out_valid), 120'd0);
      @(posedge clk); #1;
    end
    send(56'd6, 64'd7, 1'b0, 1'b0, 1'b0, "R8");
    drain();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset_state();
    t_latency();
    t_fixed_corners();
    t_frac_corners();
    t_digit_patterns();
    t_shift_flag();
    t_back_to_back();
    t_stream(200, 1'b0);
    t_stream(300, 1'b1);
    t_reset_flush();
    chk(n_recv <= n_sent, "R1", "no duplicate results", 120'(n_recv), 120'(n_sent));
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule